// File: doc/BRIEF.md
# Deep Standby Power-Mode Controller

This block sequences the power modes of a small processor subsystem. Software programs a few control registers through a simple write port. These registers hold a standby control word, a retention keep mask, a wake-source enable mask and a per-source wake edge mode. Software then raises a sleep request strobe. When both the standby bit and the deep bit are set, the controller enters deep standby. It removes power-enable from the clock, peripheral and core domains and keeps power only on the retention RAM banks chosen by the keep mask and on the always-on timer domain. It also freezes the output pins at the values they had on the entry edge.

An enabled external wake pin, set to detect a single rising or falling edge, ends deep standby. The controller records the source in a sticky flag register. It powers the domains back up one per cycle in the order clock, peripherals, core. It then gives a one-cycle wake-reset pulse and releases the pin freeze in the following cycle. All control registers except the flags come back at their reset values. A sleep request with only the standby bit set gives a one-cycle ordinary-standby indication instead. Writes pass through a one-cycle pending stage, and a sleep request that meets a pending write waits until the write has landed.

The state machine has seven states. RUN is the normal state. LIGHT is the one-cycle ordinary-standby indication. DEEP is the powered-down state. UP_CLK, UP_PER and UP_CORE are the staged power-up states, and WRST is the wake-reset cycle. The transitions are as follows:
- RUN to DEEP on an accepted deep request.
- RUN to LIGHT on a standby-only request.
- LIGHT to RUN unconditionally.
- DEEP to UP_CLK on a qualified wake edge.
- UP_CLK to UP_PER, UP_PER to UP_CORE, UP_CORE to WRST and WRST to RUN, one per cycle.
- A refused or standby-off request leaves the state at RUN.

Top module: `dstby_ctrl`

## Requirements
- R1: A sleep request sampled in RUN with no write busy, standby bit (ctrl bit 0) = 1, deep bit (ctrl bit 1) = 1 and no enabled flag pending moves the block to DEEP on that edge; in_deep is high from that edge until a wake edge is sampled. After reset in_deep is 0 and every power-enable is 1.
- R2: A request with standby = 1 and deep = 0 raises stby_ind for exactly one cycle and gates no domain. A request with standby = 0 changes no output.
- R3: In DEEP, pwr_core, pwr_clk and pwr_periph are 0. pwr_aon is always 1.
- R4: In DEEP, pwr_ram[i] equals keep-mask bit i (register address 1, bits [3:0]). In every other state all banks are powered.
- R5: The ctrl, keep, enable and edge registers (addresses 0 to 3) read 0 after the WRST cycle. The flag register (address 4) keeps its value. rd_data is a combinational read of the applied register values, and unused addresses read 0.
- R6: pin_out equals pin_func outside the hold. From the entry edge through the WRST cycle, pin_out holds the pin_func value sampled on the entry edge.
- R7: A wake pin ends DEEP only if its bit in the enable register (address 2, bit i) is 1.
- R8: The edge mode of source i is edge-register bits [2i+1:2i]: 01 rising, 10 falling. Modes 00 (level) and 11 (both edges) never wake, and neither does an edge opposite to the programmed one.
- R9: On the waking edge the flag bits of every source that qualified in that cycle are set. A write to address 4 clears the flag bits written as 1.
- R10: After the wake edge: pwr_clk rises first. pwr_periph rises one cycle later. pwr_core rises one cycle after that. wake_rst is then high for exactly one cycle. The pin hold releases in the next cycle.
- R11: A deep request with (flags AND enable) non-zero is refused: the state stays RUN and no output changes.
- R12: A write sampled on edge k is applied on edge k+1. A sleep request sampled while a write is accepted or pending is deferred. It acts on the first edge with no write busy, using the updated registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe (accepted in RUN only) |
| wr_addr | input | AW (3) | Write address: 0 ctrl, 1 keep, 2 enable, 3 edge mode, 4 flags |
| wr_data | input | DW (8) | Write data |
| rd_addr | input | AW (3) | Read address |
| rd_data | output | DW (8) | Read data, combinational |
| sleep_req | input | 1 | Sleep request strobe |
| wake_pin | input | NWAKE (4) | External wake source pins |
| pin_func | input | NPIN (8) | Functional output pin values from the subsystem |
| pin_out | output | NPIN (8) | Output pins, frozen during the hold |
| pwr_core | output | 1 | Core domain power-enable |
| pwr_clk | output | 1 | Clock domain power-enable |
| pwr_periph | output | 1 | Peripheral domain power-enable |
| pwr_ram | output | NBANK (4) | Retention RAM bank power-enables |
| pwr_aon | output | 1 | Always-on timer domain enable |
| stby_ind | output | 1 | Ordinary-standby indication |
| in_deep | output | 1 | High while in deep standby |
| wake_rst | output | 1 | One-cycle wake-reset pulse |

## Verification
Every output here is a Moore function of the state register, so the effect of a request, a wake edge or a write shows one edge after it is sampled. The two exceptions are a sleep request that meets a busy write, which acts one edge later, and rd_data, which follows the applied registers two edges after the write strobe. The bench drives inputs 2 ns after a rising edge and lets its behavioural model advance on each edge. It compares every output against the model at the falling edge. Directed checks are read right after the edge they target, so each power-up step, the reset pulse and the hold release are pinned to their own cycle.

// File: rtl/dstby_pkg.sv
package dstby_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_LIGHT,
        ST_DEEP,
        ST_UP_CLK,
        ST_UP_PER,
        ST_UP_CORE,
        ST_WRST
    } pm_state_e;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_KEEP = 3'd1;
    localparam logic [2:0] ADDR_WEN  = 3'd2;
    localparam logic [2:0] ADDR_EDGE = 3'd3;
    localparam logic [2:0] ADDR_FLAG = 3'd4;

    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;

endpackage

// File: rtl/dstby_regs.sv
module dstby_regs
    import dstby_pkg::*;
#(
    parameter int NWAKE = 4,
    parameter int NBANK = 4,
    parameter int DW    = 8,
    parameter int AW    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_acc,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    input  logic               soft_clr,
    input  logic [NWAKE-1:0]   flag_set,
    output logic               busy,
    output logic               stby,
    output logic               deep,
    output logic [NBANK-1:0]   keep,
    output logic [NWAKE-1:0]   wen,
    output logic [2*NWAKE-1:0] mode,
    output logic [NWAKE-1:0]   flags
);

    localparam int MW = 2 * NWAKE;

    logic          pend_v;
    logic [AW-1:0] pend_a;
    logic [DW-1:0] pend_d;
    logic [NWAKE-1:0] flag_clr;

    // one-cycle pending stage in front of the registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_a <= '0;
            pend_d <= '0;
        end else begin
            pend_v <= wr_acc;
            if (wr_acc) begin
                pend_a <= wr_addr;
                pend_d <= wr_data;
            end
        end
    end

    assign busy = pend_v | wr_acc;

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            stby <= 1'b0;
            deep <= 1'b0;
            keep <= '0;
            wen  <= '0;
            mode <= '0;
        end else if (pend_v) begin
            case (pend_a)
                ADDR_CTRL: begin
                    stby <= pend_d[0];
                    deep <= pend_d[1];
                end
                ADDR_KEEP: keep <= pend_d[NBANK-1:0];
                ADDR_WEN:  wen  <= pend_d[NWAKE-1:0];
                ADDR_EDGE: mode <= pend_d[MW-1:0];
                default: ;
            endcase
        end
    end

    assign flag_clr = (pend_v && pend_a == ADDR_FLAG) ? pend_d[NWAKE-1:0] : '0;

    // flags survive the wake clear; write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~flag_clr) | flag_set;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: rd_data[1:0]       = {deep, stby};
            ADDR_KEEP: rd_data[NBANK-1:0] = keep;
            ADDR_WEN:  rd_data[NWAKE-1:0] = wen;
            ADDR_EDGE: rd_data[MW-1:0]    = mode;
            ADDR_FLAG: rd_data[NWAKE-1:0] = flags;
            default:   rd_data            = '0;
        endcase
    end

endmodule

// File: rtl/dstby_wake.sv
module dstby_wake
    import dstby_pkg::*;
#(
    parameter int NWAKE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NWAKE-1:0]   pins,
    input  logic [NWAKE-1:0]   wen,
    input  logic [2*NWAKE-1:0] mode,
    output logic [NWAKE-1:0]   ev
);

    logic [NWAKE-1:0] pin_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pins;
        end
    end

    for (genvar i = 0; i < NWAKE; i++) begin : g_src
        logic rise_hit;
        logic fall_hit;
        assign rise_hit = (mode[2*i +: 2] == EDGE_RISE) &&  pins[i] && !pin_q[i];
        assign fall_hit = (mode[2*i +: 2] == EDGE_FALL) && !pins[i] &&  pin_q[i];
        assign ev[i]    = wen[i] && (rise_hit || fall_hit);
    end

endmodule

// File: rtl/dstby_hold.sv
module dstby_hold #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            hold,
    input  logic [NPIN-1:0] pin_func,
    output logic [NPIN-1:0] pin_out
);

    logic [NPIN-1:0] frozen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen <= '0;
        end else if (capture) begin
            frozen <= pin_func;
        end
    end

    assign pin_out = hold ? frozen : pin_func;

endmodule

// File: rtl/dstby_ctrl.sv
module dstby_ctrl
    import dstby_pkg::*;
#(
    parameter int NWAKE = 4,
    parameter int NBANK = 4,
    parameter int NPIN  = 8,
    parameter int DW    = 8,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             sleep_req,
    input  logic [NWAKE-1:0] wake_pin,
    input  logic [NPIN-1:0]  pin_func,
    output logic [NPIN-1:0]  pin_out,
    output logic             pwr_core,
    output logic             pwr_clk,
    output logic             pwr_periph,
    output logic [NBANK-1:0] pwr_ram,
    output logic             pwr_aon,
    output logic             stby_ind,
    output logic             in_deep,
    output logic             wake_rst
);

    pm_state_e state_q, state_d;

    logic               defer_q;
    logic               wr_acc;
    logic               sleep_acc;
    logic               go;
    logic               busy;
    logic               stby;
    logic               deep;
    logic [NBANK-1:0]   keep;
    logic [NWAKE-1:0]   wen;
    logic [2*NWAKE-1:0] mode;
    logic [NWAKE-1:0]   flags;
    logic [NWAKE-1:0]   ev;
    logic [NWAKE-1:0]   flag_set;
    logic               entry_ok;
    logic               capture;
    logic               hold;
    logic               soft_clr;

    assign wr_acc    = wr_en && (state_q == ST_RUN);
    assign sleep_acc = sleep_req && (state_q == ST_RUN);
    assign go        = (sleep_acc || defer_q) && !busy;
    assign entry_ok  = stby && deep && ((flags & wen) == '0);
    assign capture   = (state_q == ST_RUN) && (state_d == ST_DEEP);
    assign flag_set  = (state_q == ST_DEEP) ? ev : '0;
    assign soft_clr  = (state_q == ST_WRST);

    dstby_regs #(
        .NWAKE(NWAKE), .NBANK(NBANK), .DW(DW), .AW(AW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_acc   (wr_acc),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .soft_clr (soft_clr),
        .flag_set (flag_set),
        .busy     (busy),
        .stby     (stby),
        .deep     (deep),
        .keep     (keep),
        .wen      (wen),
        .mode     (mode),
        .flags    (flags)
    );

    dstby_wake #(.NWAKE(NWAKE)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (wake_pin),
        .wen   (wen),
        .mode  (mode),
        .ev    (ev)
    );

    dstby_hold #(.NPIN(NPIN)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .hold     (hold),
        .pin_func (pin_func),
        .pin_out  (pin_out)
    );

    // state register and deferred-request flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            defer_q <= 1'b0;
        end else begin
            state_q <= state_d;
            defer_q <= go ? 1'b0 : (defer_q || (sleep_acc && busy));
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (go) begin
                    if (stby && deep) begin
                        if (entry_ok) state_d = ST_DEEP;
                    end else if (stby) begin
                        state_d = ST_LIGHT;
                    end
                end
            end
            ST_LIGHT:   state_d = ST_RUN;
            ST_DEEP:    if (|ev) state_d = ST_UP_CLK;
            ST_UP_CLK:  state_d = ST_UP_PER;
            ST_UP_PER:  state_d = ST_UP_CORE;
            ST_UP_CORE: state_d = ST_WRST;
            ST_WRST:    state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // Moore outputs
    always_comb begin
        pwr_core   = 1'b1;
        pwr_clk    = 1'b1;
        pwr_periph = 1'b1;
        pwr_ram    = '1;
        stby_ind   = 1'b0;
        in_deep    = 1'b0;
        wake_rst   = 1'b0;
        hold       = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_LIGHT: stby_ind = 1'b1;
            ST_DEEP: begin
                pwr_core   = 1'b0;
                pwr_clk    = 1'b0;
                pwr_periph = 1'b0;
                pwr_ram    = keep;
                in_deep    = 1'b1;
                hold       = 1'b1;
            end
            ST_UP_CLK: begin
                pwr_core   = 1'b0;
                pwr_periph = 1'b0;
                hold       = 1'b1;
            end
            ST_UP_PER: begin
                pwr_core = 1'b0;
                hold     = 1'b1;
            end
            ST_UP_CORE: hold = 1'b1;
            ST_WRST: begin
                wake_rst = 1'b1;
                hold     = 1'b1;
            end
            default: ;
        endcase
    end

    assign pwr_aon = 1'b1;

endmodule

// File: rtl/dstby_ctrl_chk.sv
module dstby_ctrl_chk #(
    parameter int NWAKE = 4,
    parameter int NBANK = 4,
    parameter int NPIN  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_deep,
    input logic             pwr_core,
    input logic             pwr_clk,
    input logic             pwr_periph,
    input logic             pwr_aon,
    input logic [NBANK-1:0] pwr_ram,
    input logic [NBANK-1:0] keep,
    input logic [NPIN-1:0]  pin_out,
    input logic [NPIN-1:0]  pin_func,
    input logic             wake_rst,
    input logic [NWAKE-1:0] flags,
    input logic [NWAKE-1:0] wen,
    input logic             busy
);

    AST_DEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        in_deep |-> (!pwr_core && !pwr_clk && !pwr_periph && pwr_aon)); // R3

    AST_RAM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_deep |-> (pwr_ram == keep)); // R4

    AST_PIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_deep) |-> (pin_out == $past(pin_func))); // R6

    AST_PIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_deep && $past(in_deep)) |-> $stable(pin_out)); // R6

    AST_PER_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_periph) |-> ($past(pwr_clk) && !pwr_core)); // R10

    AST_CORE_AFTER_PER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_core) |-> ($past(pwr_periph) && pwr_clk)); // R10

    AST_WRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst |=> !wake_rst); // R10

    AST_FLAG_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_deep) |-> (flags != '0)); // R9

    AST_NO_PENDING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_deep) |-> (($past(flags) & $past(wen)) == '0)); // R11

    AST_NO_ENTRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_deep) |-> !$past(busy)); // R12

endmodule

bind dstby_ctrl dstby_ctrl_chk #(
    .NWAKE(NWAKE), .NBANK(NBANK), .NPIN(NPIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_deep    (in_deep),
    .pwr_core   (pwr_core),
    .pwr_clk    (pwr_clk),
    .pwr_periph (pwr_periph),
    .pwr_aon    (pwr_aon),
    .pwr_ram    (pwr_ram),
    .keep       (keep),
    .pin_out    (pin_out),
    .pin_func   (pin_func),
    .wake_rst   (wake_rst),
    .flags      (flags),
    .wen        (wen),
    .busy       (busy)
);

// File: tb/dstby_ctrl_tb_top.sv
module dstby_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sleep_req = 1'b0;
    logic [3:0] wake_pin = '0;
    logic [7:0] pin_func = '0;
    logic [7:0] pin_out;
    logic       pwr_core, pwr_clk, pwr_periph, pwr_aon;
    logic [3:0] pwr_ram;
    logic       stby_ind, in_deep, wake_rst;

    always #10 clk = ~clk;

    dstby_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sleep_req(sleep_req), .wake_pin(wake_pin), .pin_func(pin_func),
        .pin_out(pin_out), .pwr_core(pwr_core), .pwr_clk(pwr_clk),
        .pwr_periph(pwr_periph), .pwr_ram(pwr_ram), .pwr_aon(pwr_aon),
        .stby_ind(stby_ind), .in_deep(in_deep), .wake_rst(wake_rst)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // behavioural reference model; states: 0 run, 1 light, 2 deep,
    // 3 clock up, 4 periph up, 5 core up, 6 wake reset
    int         m_st = 0;
    bit         m_def = 0;
    bit [1:0]   m_ctrl = 0;
    bit [3:0]   m_keep = 0, m_wen = 0, m_flags = 0, m_prev = 0;
    bit [7:0]   m_mode = 0, m_held = 0;
    int         qa[$];
    int         qd[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_def = 0; m_ctrl = 0; m_keep = 0; m_wen = 0;
            m_flags = 0; m_prev = 0; m_mode = 0; m_held = 0;
            qa.delete(); qd.delete();
        end else begin
            bit wacc, sacc, busy, go;
            bit [3:0] ev, clr;
            int ns;
            wacc = wr_en && m_st == 0;
            sacc = sleep_req && m_st == 0;
            busy = (qa.size() > 0) || wacc;
            go   = (sacc || m_def) && !busy;
            ev   = 0;
            for (int i = 0; i < 4; i++) begin
                if (m_wen[i] && m_mode[2*i +: 2] == 2'b01 && wake_pin[i] && !m_prev[i]) ev[i] = 1;
                if (m_wen[i] && m_mode[2*i +: 2] == 2'b10 && !wake_pin[i] && m_prev[i]) ev[i] = 1;
            end
            ns = m_st;
            case (m_st)
                0: if (go) begin
                       if (m_ctrl == 2'b11) begin
                           if ((m_flags & m_wen) == 0) begin
                               ns = 2;
                               m_held = pin_func;
                           end
                       end else if (m_ctrl[0]) ns = 1;
                   end
                1: ns = 0;
                2: if (ev != 0) ns = 3;
                6: ns = 0;
                default: ns = m_st + 1;
            endcase
            clr = 0;
            if (m_st == 6) begin
                m_ctrl = 0; m_keep = 0; m_wen = 0; m_mode = 0;
            end else if (qa.size() > 0) begin
                int a, d;
                a = qa.pop_front();
                d = qd.pop_front();
                case (a)
                    0: m_ctrl = d[1:0];
                    1: m_keep = d[3:0];
                    2: m_wen  = d[3:0];
                    3: m_mode = d[7:0];
                    4: clr    = d[3:0];
                    default: ;
                endcase
            end
            m_flags = (m_flags & ~clr) | ((m_st == 2) ? ev : 4'b0);
            if (wacc) begin
                qa.push_back(int'(wr_addr));
                qd.push_back(int'(wr_data));
            end
            m_def = go ? 1'b0 : (m_def || (sacc && busy));
            m_prev = wake_pin;
            m_st = ns;
        end
    end

    function automatic int m_read(input int a);
        case (a)
            0: return int'(m_ctrl);
            1: return int'(m_keep);
            2: return int'(m_wen);
            3: return int'(m_mode);
            4: return int'(m_flags);
            default: return 0;
        endcase
    endfunction

    // compare every output with the model on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit hold;
            hold = (m_st >= 2);
            chk("R1 in_deep", in_deep, m_st == 2);
            chk("R2 stby_ind", stby_ind, m_st == 1);
            chk("R3 pwr_core", pwr_core, !(m_st >= 2 && m_st <= 4));
            chk("R3 pwr_periph", pwr_periph, !(m_st == 2 || m_st == 3));
            chk("R10 pwr_clk", pwr_clk, m_st != 2);
            chk("R3 pwr_aon", pwr_aon, 1);
            chk("R4 pwr_ram", pwr_ram, (m_st == 2) ? int'(m_keep) : 15);
            chk("R6 pin_out", pin_out, hold ? int'(m_held) : int'(pin_func));
            chk("R10 wake_rst", wake_rst, m_st == 6);
            chk("R5 rd_data", rd_data, m_read(int'(rd_addr)));
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
        step();
        wr_en = 0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1;
        step();
        sleep_req = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        wake_pin = 4'b0010;
        pin_func = 8'hA5;
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 reset in_deep", in_deep, 0);
        chk("R1 reset pwr_core", pwr_core, 1);

        // ordinary standby
        wr(0, 1); step();
        pulse_sleep();
        chk("R2 light pulse", stby_ind, 1);
        chk("R2 no gating", pwr_clk, 1);
        step();
        chk("R2 pulse one cycle", stby_ind, 0);

        // deep bit alone does nothing
        wr(0, 2); step();
        pulse_sleep();
        chk("R2 standby off", stby_ind, 0);
        chk("R2 standby off deep", in_deep, 0);

        // round 1: keep 0101, enable 1011, modes src3 both, src2 rise, src1 fall, src0 rise
        wr(1, 4'b0101);
        wr(2, 4'b1011);
        wr(4'd3, 8'hD9);
        wr(0, 3);
        pulse_sleep();
        chk("R12 deferred", in_deep, 0);
        step();
        chk("R12 entry after write", in_deep, 1);
        chk("R4 keep 0101", pwr_ram, 4'b0101);
        chk("R3 core off", pwr_core, 0);
        pin_func = 8'h3C;
        step();
        chk("R6 frozen", pin_out, 8'hA5);
        wake_pin = 4'b0110; step(); step();
        chk("R7 disabled source", in_deep, 1);
        wake_pin = 4'b1110; step();
        wake_pin = 4'b0110; step(); step();
        chk("R8 both-edge mode", in_deep, 1);
        wake_pin = 4'b0111; step();
        chk("R10 clk first", pwr_clk, 1);
        chk("R10 periph later", pwr_periph, 0);
        step();
        chk("R10 periph second", pwr_periph, 1);
        chk("R10 core later", pwr_core, 0);
        step();
        chk("R10 core third", pwr_core, 1);
        chk("R10 no reset yet", wake_rst, 0);
        step();
        chk("R10 reset pulse", wake_rst, 1);
        chk("R6 hold in reset", pin_out, 8'hA5);
        step();
        chk("R10 reset ended", wake_rst, 0);
        chk("R6 released", pin_out, 8'h3C);
        rd_addr = 0; #1; chk("R5 ctrl cleared", rd_data, 0);
        rd_addr = 2; #1; chk("R5 enable cleared", rd_data, 0);
        rd_addr = 4; #1; chk("R9 flag src0", rd_data, 1);

        // refusal with enabled flag pending
        wr(2, 1);
        wr(0, 3);
        step();
        pulse_sleep();
        chk("R11 refused", in_deep, 0);
        chk("R11 no light", stby_ind, 0);
        step();
        chk("R11 stays run", in_deep, 0);

        // clear flag, round 2: src2 enabled in level mode
        wr(4, 1); step();
        #1; chk("R9 flag cleared", rd_data, 0);
        wr(1, 4'b1010);
        wr(2, 4'b0111);
        wr(3, 8'h09);
        step();
        pulse_sleep();
        chk("R1 second entry", in_deep, 1);
        chk("R4 keep 1010", pwr_ram, 4'b1010);
        wake_pin = 4'b0011; step();
        wake_pin = 4'b0111; step(); step();
        chk("R8 level mode", in_deep, 1);
        wake_pin = 4'b0110; step(); step();
        chk("R8 opposite edge", in_deep, 1);
        wake_pin = 4'b0100; step();
        chk("R7 enabled fall wakes", in_deep, 0);
        repeat (5) step();
        rd_addr = 4; #1;
        chk("R9 flag src1", rd_data, 2);
        step();
        finish_run();
    end

endmodule